// File: doc/BRIEF.md
# Converter Output Formatting Pipeline

This block sits between a data converter core and the parallel output pins. On every rising clock edge it accepts one raw conversion result and that sample's out-of-range flag. It carries both through a fixed-depth register pipeline, so the code and its flag leave the block together. At the output the block applies the selected number coding. The raw code is offset binary. It can be passed through unchanged, or it can be shown as two's complement by inverting its most significant bit. The data pins can also be released to high impedance.

The block also splits the delayed out-of-range flag into an above-range indication and a below-range indication. It does this by combining the flag with the offset-binary MSB of the same sample. The MSB used is always the one stored in the pipeline, whatever coding is currently selected.

The stream has no back-pressure. The converter core produces one sample per clock and cannot stall, so the block takes a sample on every edge and has no ready signal. `fill_ok` is the output-side valid. It goes high once the pipeline holds only real samples and stays high until the next reset. The coding select and the output enable are static control straps. They act combinationally on the outputs.

Top module: `afp_out_pipe`

## Requirements
- R1: A code present on `raw_code` at a rising edge appears on `dout` after the LAT-th rising edge, counting the capture edge as the first (LAT = 7 by default). A new sample is accepted on every edge.
- R2: `oor_q` carries the `raw_oor` value of the same sample as `dout`, with exactly the same LAT-edge delay.
- R3: With `fmt_twos` = 0, `dout` equals the stored offset-binary code. With `fmt_twos` = 1, `dout` equals that code with bit CODE_W-1 inverted (two's complement). A change of `fmt_twos` shows in the same cycle.
- R4: With `oe_n` = 1, `dout` is high impedance and `dout_drive` = 0. With `oe_n` = 0, `dout` is driven and `dout_drive` = 1. `oe_n` has no effect on `oor_q`, `over_q`, `under_q` or `fill_ok`.
- R5: `over_q` = `oor_q` AND (stored offset-binary bit CODE_W-1). `under_q` = `oor_q` AND NOT that bit. Both are independent of `fmt_twos`, so at most one of them is high.
- R6: While `rst_n` is low at a rising edge, every pipeline stage clears to zero. After that edge the block shows code 0 (offset binary), `oor_q` = 0, `over_q` = 0, `under_q` = 0 and `fill_ok` = 0.
- R7: `fill_ok` is 0 until the LAT-th rising edge after reset is released. From that edge on it is 1 and stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; samples are taken on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| raw_code | input | CODE_W | Offset-binary conversion result from the core |
| raw_oor | input | 1 | Out-of-range flag for the same sample |
| fmt_twos | input | 1 | Coding select: 1 = two's complement, 0 = offset binary |
| oe_n | input | 1 | Output enable, active low; 1 releases `dout` |
| dout | output | CODE_W | Formatted data, high impedance while disabled |
| dout_drive | output | 1 | High while `dout` is being driven |
| oor_q | output | 1 | Delayed out-of-range flag |
| over_q | output | 1 | Sample was above the top of the range |
| under_q | output | 1 | Sample was below the bottom of the range |
| fill_ok | output | 1 | Output valid: the pipeline holds real samples |

## Verification
The bound checker checks four things on every cycle. The over and under flags are mutually exclusive, and together they equal the delayed flag. The over flag always matches a set MSB on the driven offset-binary output. The valid flag never drops outside reset, and drive status follows the enable strap. The exact LAT-edge alignment of code and flag can only be shown by the bench's scenarios, as can the zero state after reset and the instant effect of coding changes on samples already in flight. The bench sweeps every code value while the coding select and the output enable toggle in windows.

// File: rtl/afp_pkg.sv
package afp_pkg;

  typedef enum logic {
    FMT_OFFSET = 1'b0,
    FMT_TWOS   = 1'b1
  } afp_fmt_e;

  typedef struct packed {
    logic above;
    logic below;
  } afp_range_t;

  // Split an out-of-range flag using the offset-binary sign bit.
  function automatic afp_range_t split_range(input logic oor, input logic ob_msb);
    afp_range_t r;
    r.above = oor & ob_msb;
    r.below = oor & ~ob_msb;
    return r;
  endfunction

endpackage

// File: rtl/afp_delay_line.sv
module afp_delay_line #(
  parameter int unsigned WIDTH = 15,
  parameter int unsigned DEPTH = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  logic [WIDTH-1:0] stage_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d_in;
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage_q[k] <= '0;
      else        stage_q[k] <= stage_q[k-1];
    end
  end

  assign d_out = stage_q[DEPTH-1];

endmodule

// File: rtl/afp_fill_tracker.sv
module afp_fill_tracker #(
  parameter int unsigned DEPTH = 7
) (
  input  logic clk,
  input  logic rst_n,
  output logic full
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [CNT_W-1:0] fill_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                fill_cnt <= '0;
    else if (fill_cnt != CNT_MAX) fill_cnt <= fill_cnt + 1'b1;
  end

  assign full = (fill_cnt == CNT_MAX);

endmodule

// File: rtl/afp_fmt_coder.sv
module afp_fmt_coder #(
  parameter int unsigned CODE_W = 14
) (
  input  logic              fmt_sel,
  input  logic [CODE_W-1:0] code_ob,
  output logic [CODE_W-1:0] code_fmt
);
  import afp_pkg::*;

  localparam int unsigned MSB = CODE_W - 1;

  afp_fmt_e fmt;
  assign fmt = afp_fmt_e'(fmt_sel);

  for (genvar b = 0; b < CODE_W; b++) begin : g_bit
    if (b == MSB) begin : g_sign
      assign code_fmt[b] = (fmt == FMT_TWOS) ? ~code_ob[b] : code_ob[b];
    end else begin : g_mag
      assign code_fmt[b] = code_ob[b];
    end
  end

endmodule

// File: rtl/afp_out_pipe.sv
module afp_out_pipe #(
  parameter int unsigned CODE_W = 14,
  parameter int unsigned LAT    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] raw_code,
  input  logic              raw_oor,
  input  logic              fmt_twos,
  input  logic              oe_n,
  output wire  [CODE_W-1:0] dout,
  output logic              dout_drive,
  output logic              oor_q,
  output logic              over_q,
  output logic              under_q,
  output logic              fill_ok
);
  import afp_pkg::*;

  localparam int unsigned LANE_W = CODE_W + 1;

  logic [LANE_W-1:0] lane_in;
  logic [LANE_W-1:0] lane_out;
  logic [CODE_W-1:0] code_ob_q;
  logic [CODE_W-1:0] code_fmt;
  afp_range_t        rng;

  // Flag and code share one lane so they cannot drift apart.
  assign lane_in = {raw_oor, raw_code};

  afp_delay_line #(
    .WIDTH (LANE_W),
    .DEPTH (LAT)
  ) u_lane (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (lane_in),
    .d_out (lane_out)
  );

  assign code_ob_q = lane_out[CODE_W-1:0];
  assign oor_q     = lane_out[CODE_W];

  afp_fmt_coder #(
    .CODE_W (CODE_W)
  ) u_coder (
    .fmt_sel  (fmt_twos),
    .code_ob  (code_ob_q),
    .code_fmt (code_fmt)
  );

  assign rng     = split_range(oor_q, code_ob_q[CODE_W-1]);
  assign over_q  = rng.above;
  assign under_q = rng.below;

  afp_fill_tracker #(
    .DEPTH (LAT)
  ) u_fill (
    .clk   (clk),
    .rst_n (rst_n),
    .full  (fill_ok)
  );

  assign dout_drive = ~oe_n;
  assign dout       = dout_drive ? code_fmt : {CODE_W{1'bz}};

endmodule

// File: rtl/afp_out_pipe_chk.sv
module afp_out_pipe_chk #(
  parameter int unsigned CODE_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fmt_twos,
  input logic              oe_n,
  input logic [CODE_W-1:0] dout,
  input logic              dout_drive,
  input logic              oor_q,
  input logic              over_q,
  input logic              under_q,
  input logic              fill_ok
);

  // R5
  range_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(over_q && under_q));

  // R5
  range_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (over_q || under_q) == oor_q);

  // R5
  over_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (over_q && dout_drive && !fmt_twos) |-> dout[CODE_W-1]);

  // R7
  fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ok |=> fill_ok);

  // R4
  drive_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_drive != oe_n);

endmodule

bind afp_out_pipe afp_out_pipe_chk #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fmt_twos   (fmt_twos),
  .oe_n       (oe_n),
  .dout       (dout),
  .dout_drive (dout_drive),
  .oor_q      (oor_q),
  .over_q     (over_q),
  .under_q    (under_q),
  .fill_ok    (fill_ok)
);

// File: tb/tb_afp_out_pipe.sv
`timescale 1ns/1ps
module tb_afp_out_pipe;

  localparam int CW    = 14;
  localparam int LAT   = 7;
  localparam int NSAMP = 1 << CW;
  localparam int MASK  = NSAMP - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] raw_code = '0;
  logic          raw_oor = 1'b0;
  logic          fmt_twos = 1'b0;
  logic          oe_n = 1'b0;
  wire  [CW-1:0] dout;
  logic          dout_drive, oor_q, over_q, under_q, fill_ok;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  afp_out_pipe #(.CODE_W(CW), .LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .raw_code(raw_code), .raw_oor(raw_oor),
    .fmt_twos(fmt_twos), .oe_n(oe_n), .dout(dout), .dout_drive(dout_drive),
    .oor_q(oor_q), .over_q(over_q), .under_q(under_q), .fill_ok(fill_ok)
  );

  // Odd multiplier mod 2^CW visits every code exactly once.
  function automatic logic [CW-1:0] code_at(int j);
    return CW'((j * 37 + 5) & MASK);
  endfunction

  function automatic logic oor_at(int j);
    return ((j % 7) == 3) || ((j % 11) == 0);
  endfunction

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, actual, expected);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] ob;
    logic          fl;
    // R6: reset state
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R6 code", int'(dout), 0);
    check("R6 oor", int'(oor_q), 0);
    check("R6 over", int'(over_q), 0);
    check("R6 under", int'(under_q), 0);
    check("R6 valid", int'(fill_ok), 0);
    fmt_twos = 1'b1;
    #0.1;
    check("R3 reset twos", int'(dout), 1 << (CW - 1));
    fmt_twos = 1'b0;
    rst_n = 1'b1;
    raw_code = code_at(0);
    raw_oor  = oor_at(0);

    for (int i = 1; i <= NSAMP + LAT; i++) begin
      int e;
      @(negedge clk);
      e = i - 1;  // edge just taken
      if (e >= LAT - 1) begin
        ob = code_at(e - LAT + 1);
        fl = oor_at(e - LAT + 1);
      end else begin
        ob = '0;
        fl = 1'b0;
      end
      // R7
      check("R7 valid", int'(fill_ok), int'(e + 1 >= LAT));
      // R2
      check("R2 flag", int'(oor_q), int'(fl));
      // R5
      check("R5 over", int'(over_q), int'(fl & ob[CW-1]));
      check("R5 under", int'(under_q), int'(fl & ~ob[CW-1]));
      // R4
      check("R4 drive", int'(dout_drive), int'(!oe_n));
      if (!oe_n) begin
        // R1 and R3
        if (fmt_twos) check("R3 twos", int'(dout), int'({~ob[CW-1], ob[CW-2:0]}));
        else          check("R1 offset", int'(dout), int'(ob));
      end
      raw_code = code_at(i);
      raw_oor  = oor_at(i);
      fmt_twos = ((i / 1000) % 2) == 1;
      oe_n     = ((i / 500) % 4) == 3;
    end

    // R3: format flips instantly on held sample
    oe_n = 1'b0;
    @(negedge clk);
    ob = code_at(NSAMP + LAT - LAT + 1);
    fmt_twos = 1'b0;
    #0.1;
    check("R3 flip off", int'(dout), int'(ob));
    fmt_twos = 1'b1;
    #0.1;
    check("R3 flip on", int'(dout), int'({~ob[CW-1], ob[CW-2:0]}));

    // R6: reset mid-stream clears everything
    rst_n = 1'b0;
    fmt_twos = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R6 re-code", int'(dout), 0);
    check("R6 re-valid", int'(fill_ok), 0);
    check("R6 re-oor", int'(oor_q), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule